// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It runs in the system clock domain and takes a one-cycle sample pulse, `rx_tick`, at the configured multiple of the bit rate: one, sixteen or sixty-four pulses per bit. The line passes through a synchronizer. While the line is idle, a low sample marks a possible start bit. In the x16 and x64 modes the start bit is checked again at its centre, and a low level that has gone away by then counts as a glitch and is dropped. After a valid start, the block samples one value per bit, in the centre of each bit time. It collects 5 to 8 data bits, least significant first, then an optional parity bit and the first stop bit.

When the stop bit has been sampled, the character goes into a holding register and `rx_ready` rises. Reading the character is signalled with `rd_ack`, which lowers `rx_ready`. The block keeps three error flags: parity, overrun and framing. Each flag stays set until the error-clear command `err_clr`. The rate factor, character length and parity mode are captured when a start is detected, so they can change between characters. Reception runs only while `rx_en` is high. Lowering it stops a frame in progress and sends the receiver back to idle.

Top module: `serial_async_rx`

## Requirements
- R1: After a synchronous reset, `rx_ready`, `rx_data` and all three error flags read zero.
- R2: While idle and enabled, a low sample on the line starts a frame. In the x16 and x64 modes the line is sampled again half a bit after that low sample, and if it is high the start is dropped and no character is produced.
- R3: Data bits arrive least significant bit first. The character is right-aligned in `rx_data` and the unused upper bits are zero.
- R4: Each data, parity and stop bit is sampled once, in the centre of its bit time. In x1 mode this is the single pulse of that bit.
- R5: `rate_sel` encodes the sample rate: 2'b01 is x1, 2'b10 is x16, 2'b11 is x64, and 2'b00 works as x1.
- R6: `len_sel` encodes the character length: 2'b00 is 5 bits, 2'b01 is 6, 2'b10 is 7 and 2'b11 is 8.
- R7: When `par_en` is 1, one parity bit follows the data. With `par_odd`=0 the data plus parity bit must hold an even number of ones, and with `par_odd`=1 an odd number. A mismatch sets `err_parity`.
- R8: If the first stop bit is sampled low, `err_frame` is set. Only the first stop bit is checked.
- R9: When a character completes, `rx_ready` goes high. `rd_ack` clears it.
- R10: If a character completes while `rx_ready` is still high and `rd_ack` is not asserted, `err_overrun` is set and `rx_data` takes the new character.
- R11: The three error flags are cleared only by `err_clr`. Neither `rd_ack` nor later error-free characters clear them.
- R12: While `rx_en` is low, line activity produces no character. Lowering it during a frame drops that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | One-cycle sample pulse at the rate multiple |
| rx_line | input | 1 | Serial input, high when idle |
| rx_en | input | 1 | Receive enable |
| rate_sel | input | 2 | Sample rate multiple select |
| len_sel | input | 2 | Character length select |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_ack | input | 1 | Character taken, clears `rx_ready` |
| err_clr | input | 1 | Clears the three error flags |
| rx_data | output | 8 | Received character, right-aligned |
| rx_ready | output | 1 | Character waiting |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_frame | output | 1 | Sticky framing error |

## Verification
The hardest cases to reach from the ports are the ones that depend on where samples fall inside a bit. The main one is a start pulse that is low at the first sample but high again at the half-bit recheck. The bench creates the sample pulses itself and holds each line level for an exact number of them. This lets it produce a start pulse only three pulses long, a frame that is cut off by lowering the enable part way through, and two characters back to back with no read between them. A framing error is driven in x1 mode only, because a low stop bit held for a full bit time at x16 would look like a new start bit.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int CHAR_W     = 8;
  localparam int MAX_FACTOR = 64;
  localparam int CNT_W      = $clog2(MAX_FACTOR);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // Last count value in one bit time, per rate code.
  function automatic logic [CNT_W-1:0] bit_last(input logic [1:0] rate);
    case (rate)
      2'b10:   bit_last = CNT_W'(15);
      2'b11:   bit_last = CNT_W'(MAX_FACTOR - 1);
      default: bit_last = '0;
    endcase
  endfunction

  // Count value at which the start bit is rechecked.
  function automatic logic [CNT_W-1:0] half_last(input logic [1:0] rate);
    case (rate)
      2'b10:   half_last = CNT_W'(7);
      2'b11:   half_last = CNT_W'(MAX_FACTOR / 2 - 1);
      default: half_last = '0;
    endcase
  endfunction
endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] stage_q;

  // Every stage resets high, the idle level of the line.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b1;
          else     stage_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b1;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/rxs_frame.sv
module rxs_frame
  import rxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              en,
  input  logic [1:0]        rate,
  input  logic [1:0]        len,
  input  logic              pen,
  input  logic              podd,
  output logic              done_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_q;
  logic [CNT_W-1:0]  half_q;
  logic [2:0]        bitn_q;
  logic [1:0]        len_q;
  logic              pen_q, podd_q, acc_q, perr_q;
  logic [CHAR_W-1:0] shreg_q;
  logic              at_mid;
  logic              last_bit;

  assign at_mid   = (cnt_q == last_q);
  assign last_bit = (bitn_q == 3'(3'd4 + {1'b0, len_q}));

  always_ff @(posedge clk) begin
    done_o <= 1'b0;
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
      half_q  <= '0;
      bitn_q  <= '0;
      len_q   <= '0;
      pen_q   <= 1'b0;
      podd_q  <= 1'b0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
      shreg_q <= '0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else if (!en) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (tick) begin
      case (state_q)
        ST_IDLE: begin
          if (!line) begin
            last_q  <= bit_last(rate);
            half_q  <= half_last(rate);
            len_q   <= len;
            pen_q   <= pen;
            podd_q  <= podd;
            acc_q   <= 1'b0;
            perr_q  <= 1'b0;
            bitn_q  <= '0;
            shreg_q <= '0;
            cnt_q   <= '0;
            state_q <= (bit_last(rate) == '0) ? ST_DATA : ST_START;
          end
        end
        ST_START: begin
          if (cnt_q == half_q) begin
            cnt_q   <= '0;
            state_q <= line ? ST_IDLE : ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (at_mid) begin
            cnt_q   <= '0;
            shreg_q <= {line, shreg_q[CHAR_W-1:1]};
            acc_q   <= acc_q ^ line;
            bitn_q  <= bitn_q + 1'b1;
            if (last_bit) state_q <= pen_q ? ST_PAR : ST_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_mid) begin
            cnt_q   <= '0;
            perr_q  <= ((acc_q ^ line) != podd_q);
            state_q <= ST_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_mid) begin
            cnt_q   <= '0;
            done_o  <= 1'b1;
            data_o  <= shreg_q >> (2'd3 - len_q);
            perr_o  <= perr_q;
            ferr_o  <= !line;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R12: a low enable returns the receiver to idle on the next edge
  a_r12_disable_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> state_q == ST_IDLE);

  // R2: leaving idle needs a low line sample taken on a pulse
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && $past(state_q) == ST_IDLE) |-> ($past(tick) && !$past(line)));

  // R4: the bit-time counter never passes its last count
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA || state_q == ST_PAR || state_q == ST_STOP) |-> cnt_q <= last_q);
endmodule

// File: rtl/rxs_buffer.sv
module rxs_buffer
  import rxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              rd_ack,
  input  logic              err_clr,
  output logic [CHAR_W-1:0] data_q,
  output logic              rdy_q,
  output logic              perr_q,
  output logic              ovr_q,
  output logic              ferr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      perr_q <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (done_i)      rdy_q <= 1'b1;
      else if (rd_ack) rdy_q <= 1'b0;
      if (done_i) data_q <= data_i;
      perr_q <= (perr_q & !err_clr) | (done_i & perr_i);
      ferr_q <= (ferr_q & !err_clr) | (done_i & ferr_i);
      ovr_q  <= (ovr_q  & !err_clr) | (done_i & rdy_q & !rd_ack);
    end
  end

  // R9: ready rises only after a completed character
  a_r9_ready_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(done_i));

  // R10: a completion onto an unread character raises overrun
  a_r10_overrun: assert property (@(posedge clk) disable iff (rst)
    (done_i && rdy_q && !rd_ack) |=> ovr_q);

  // R11: error flags fall only after an error-clear command
  a_r11_perr_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(perr_q) |-> $past(err_clr));
  a_r11_ferr_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(ferr_q) |-> $past(err_clr));
  a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(ovr_q) |-> $past(err_clr));
endmodule

// File: rtl/serial_async_rx.sv
module serial_async_rx
  import rxs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_tick,
  input  logic              rx_line,
  input  logic              rx_en,
  input  logic [1:0]        rate_sel,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_ack,
  input  logic              err_clr,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              err_frame
);
  logic              line_s;
  logic              done_w, perr_w, ferr_w;
  logic [CHAR_W-1:0] char_w;

  rxs_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_in(rx_line), .q_out(line_s)
  );

  rxs_frame frame_i (
    .clk(clk), .rst(rst), .tick(rx_tick), .line(line_s), .en(rx_en),
    .rate(rate_sel), .len(len_sel), .pen(par_en), .podd(par_odd),
    .done_o(done_w), .data_o(char_w), .perr_o(perr_w), .ferr_o(ferr_w)
  );

  rxs_buffer buffer_i (
    .clk(clk), .rst(rst), .done_i(done_w), .data_i(char_w),
    .perr_i(perr_w), .ferr_i(ferr_w), .rd_ack(rd_ack), .err_clr(err_clr),
    .data_q(rx_data), .rdy_q(rx_ready), .perr_q(err_parity),
    .ovr_q(err_overrun), .ferr_q(err_frame)
  );
endmodule

// File: tb/serial_async_rx_tb_top.sv
module serial_async_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_tick = 1'b0, rx_line = 1'b1, rx_en = 1'b0;
  logic [1:0] rate_sel = 2'b10, len_sel = 2'b11;
  logic       par_en = 1'b0, par_odd = 1'b0, rd_ack = 1'b0, err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, err_parity, err_overrun, err_frame;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_async_rx dut_i (
    .clk(clk), .rst(rst), .rx_tick(rx_tick), .rx_line(rx_line), .rx_en(rx_en),
    .rate_sel(rate_sel), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .rd_ack(rd_ack), .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready),
    .err_parity(err_parity), .err_overrun(err_overrun), .err_frame(err_frame)
  );

  // Each vector: [23:22] rate, [21:20] len, [19] par_en, [18] par_odd,
  // [17] stop level, [16] flip parity, [15:8] byte sent, [7:0] expected data
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    {2'b10, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'hA5},
    {2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'hF3, 8'h13},
    {2'b11, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 8'hDA, 8'h5A},
    {2'b10, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 8'h2C, 8'h2C},
    {2'b10, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 8'h81},
    {2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C},
    {2'b00, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 8'h80, 8'h00},
    {2'b11, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick1();
    repeat (2) @(negedge clk);
    rx_tick = 1'b1;
    @(negedge clk);
    rx_tick = 1'b0;
  endtask

  task automatic send_bit(input logic v, input int n);
    rx_line = v;
    repeat (n) tick1();
  endtask

  function automatic int factor(input logic [1:0] r);
    case (r)
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 1;
    endcase
  endfunction

  task automatic send_frame(input logic [1:0] r, input logic [1:0] l, input logic pe,
                            input logic po, input logic [7:0] d, input logic stopv,
                            input logic badp);
    int n, nb;
    logic [7:0] m;
    n = factor(r);
    nb = 5 + int'(l);
    m = d & 8'((1 << nb) - 1);
    rate_sel = r; len_sel = l; par_en = pe; par_odd = po;
    send_bit(1'b0, n);
    for (int i = 0; i < nb; i++) send_bit(d[i], n);
    if (pe) send_bit((^m) ^ po ^ badp, n);
    send_bit(stopv, n);
    send_bit(1'b1, 2);
  endtask

  task automatic pulse(input bit ack, input bit clr);
    @(negedge clk);
    rd_ack = ack; err_clr = clr;
    @(negedge clk);
    rd_ack = 1'b0; err_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 ready", rx_ready, 0);
    check("R1 data", rx_data, 0);
    check("R1 flags", {err_parity, err_overrun, err_frame}, 0);
    rx_en = 1'b1;
    send_bit(1'b1, 4);

    // Vector walk: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v][23:22], VEC[v][21:20], VEC[v][19], VEC[v][18],
                 VEC[v][15:8], VEC[v][17], VEC[v][16]);
      @(negedge clk);
      check($sformatf("R9 ready vec%0d", v), rx_ready, 1);
      check($sformatf("R3 R5 R6 data vec%0d", v), rx_data, VEC[v][7:0]);
      check($sformatf("R7 parity vec%0d", v), err_parity, VEC[v][19] & VEC[v][16]);
      check($sformatf("R8 frame vec%0d", v), err_frame, !VEC[v][17]);
      check($sformatf("R10 no overrun vec%0d", v), err_overrun, 0);
      pulse(1'b1, 1'b1);
      check($sformatf("R9 ack clears vec%0d", v), rx_ready, 0);
    end

    // R11: parity flag survives a read and a good character, cleared only by err_clr
    send_frame(2'b10, 2'b11, 1'b1, 1'b1, 8'h11, 1'b1, 1'b1);
    pulse(1'b1, 1'b0);
    check("R11 perr after ack", err_parity, 1);
    send_frame(2'b10, 2'b11, 1'b1, 1'b1, 8'h22, 1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    check("R11 perr after good char", err_parity, 1);
    pulse(1'b0, 1'b1);
    check("R11 perr cleared", err_parity, 0);

    // R10: two characters without a read
    send_frame(2'b01, 2'b11, 1'b0, 1'b0, 8'h6B, 1'b1, 1'b0);
    send_frame(2'b01, 2'b11, 1'b0, 1'b0, 8'hC4, 1'b1, 1'b0);
    @(negedge clk);
    check("R10 overrun set", err_overrun, 1);
    check("R10 data overwritten", rx_data, 8'hC4);
    pulse(1'b1, 1'b0);
    check("R11 overrun after ack", err_overrun, 1);
    pulse(1'b0, 1'b1);
    check("R11 overrun cleared", err_overrun, 0);

    // R2: short start glitch at x16 is dropped
    rate_sel = 2'b10;
    send_bit(1'b0, 3);
    send_bit(1'b1, 40);
    check("R2 glitch dropped", rx_ready, 0);
    send_frame(2'b10, 2'b11, 1'b0, 1'b0, 8'h5E, 1'b1, 1'b0);
    @(negedge clk);
    check("R2 after glitch data", rx_data, 8'h5E);
    pulse(1'b1, 1'b0);

    // R12: disabled receiver ignores a whole frame
    rx_en = 1'b0;
    send_frame(2'b10, 2'b11, 1'b0, 1'b0, 8'h99, 1'b0, 1'b0);
    @(negedge clk);
    check("R12 disabled no ready", rx_ready, 0);
    check("R12 disabled data held", rx_data, 8'h5E);
    check("R12 disabled no frame err", err_frame, 0);

    // R12: dropping enable mid-frame discards it
    rx_en = 1'b1;
    rate_sel = 2'b10;
    send_bit(1'b0, 16);
    send_bit(1'b1, 16);
    send_bit(1'b0, 16);
    rx_en = 1'b0;
    send_bit(1'b1, 4);
    rx_en = 1'b1;
    send_bit(1'b1, 100);
    check("R12 aborted no ready", rx_ready, 0);
    send_frame(2'b10, 2'b11, 1'b0, 1'b0, 8'h37, 1'b1, 1'b0);
    @(negedge clk);
    check("R12 after abort data", rx_data, 8'h37);
    check("R12 after abort ready", rx_ready, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule